// File: doc/BRIEF.md
# Flash Query and Device-ID Read Responder

This block forms the read data of a memory-mapped flash bank whose read path changes with the current read mode. In array mode the word delivered by the storage is forwarded untouched. In the other three modes the block builds a 16-bit answer: the status byte, a device-identification entry, or one byte of the common flash query table. The answer is then spread across the 32-bit bus as two 16-bit chips placed side by side would present it.

Several geometry bytes of the query table are not stored. They are derived at run time from a configured total size, given as its base-2 logarithm, so one netlist serves any bank size up to the address range. The command decoder that chooses the mode, the status register and the lock bits all live outside. This block only reads them. Every result is registered and appears one clock after the inputs that produced it.

Top module: `flash_query_resp`

## Requirements
- R1: While rst_n is low, and after it rises until the first clock edge, rd_data is 0.
- R2: With rd_mode = 0 (array), rd_data equals the mem_rdata sampled at the previous clock edge, whatever rd_size is.
- R3: With rd_mode = 1 (status), the 16-bit value is {8'h00, status}.
- R4: With rd_mode = 3 (query), the table index is rd_addr >> 2 and the value is the table byte zero-extended to 16 bits. Indices 0x10 to 0x16 give 0x51, 0x52, 0x59, 0x01, 0x00, 0x31, 0x00.
- R5: Query index 0x27 gives cfg_size_log2 - 1, the log2 of the size of one chip.
- R6: Query indices 0x2D and 0x2E give the low and high bytes of (2^(cfg_size_log2 - 16)) - 1, which is the erase block count minus one for 64 KiB blocks.
- R7: Query indices 0x2F and 0x30 give 0x80 and 0x00, the 32 KiB per-chip block size in units of 256 bytes.
- R8: Query indices 0x31 to 0x35 give 0x50, 0x52, 0x49, 0x31, 0x30, and index 0x2A gives 0x06, the per-chip write buffer log2.
- R9: Any query index of 0x44 or above gives 0.
- R10: With rd_mode = 2 (device ID), the entry is (rd_addr & 0x7FF) >> 2. Entry 0 gives 0x0000 and entry 1 gives 0xFFFF. Entry 2 gives lock_bits[rd_addr >> 16]. Every other entry gives 0.
- R11: In a non-array mode with rd_size = 2 (32-bit) or 3, the 16-bit value appears in both bits [31:16] and bits [15:0].
- R12: In a non-array mode with rd_size = 1 (16-bit), rd_data is {16'h0000, value}.
- R13: In a non-array mode with rd_size = 0 (8-bit), rd_data is {24'h0, value[7:0]}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_mode | input | 2 | 0 array, 1 status, 2 device ID, 3 query |
| rd_size | input | 2 | 0 byte, 1 halfword, 2 or 3 word |
| rd_addr | input | ADDR_W (24) | Byte offset of the read inside the bank |
| mem_rdata | input | 32 | Data word from the storage array |
| status | input | 8 | Current status byte |
| lock_bits | input | 2^(ADDR_W-BLOCK_LOG2) (256) | One lock flag per 64 KiB erase block |
| cfg_size_log2 | input | 6 | log2 of the total bank size in bytes, 16 to ADDR_W |
| rd_data | output | 32 | Registered read data |

## Verification
A change of mode and a change of address or access size can fall on the same clock edge. In that case the registered word must belong entirely to the new mode, address and size, and nothing may carry over from the previous cycle. The bench provokes this by switching between array, query, device-ID and status reads on consecutive cycles, each with a different size. It judges every result against the constant that the requirements fix for that single cycle's inputs. A second coincidence comes from the configured size: it changes the computed geometry bytes, so the same query indices are read again at a second bank size.

// File: rtl/fqr_pkg.sv
package fqr_pkg;
   typedef enum logic [1:0] {
      MODE_ARRAY  = 2'd0,
      MODE_STATUS = 2'd1,
      MODE_DEVID  = 2'd2,
      MODE_QUERY  = 2'd3
   } rd_mode_e;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_HALF = 2'd1,
      SZ_WORD = 2'd2,
      SZ_WIDE = 2'd3
   } rd_size_e;

   // one past the last defined query table entry
   localparam int QRY_TBL_LEN = 'h44;
endpackage

// File: rtl/fqr_query_rom.sv
module fqr_query_rom
   import fqr_pkg::*;
#(
   parameter int IDX_W      = 22,
   parameter int CHIPS      = 2,
   parameter int BLOCK_LOG2 = 16,
   parameter int WBUF_LOG2  = 7
) (
   input  logic [IDX_W-1:0] idx,
   input  logic [5:0]       cfg_size_log2,
   output logic [7:0]       q_byte
);
   localparam int          BLK_UNITS_I = (1 << BLOCK_LOG2) / CHIPS / 256;
   localparam logic [15:0] BLK_UNITS   = 16'(BLK_UNITS_I);
   localparam logic [7:0]  WBUF_CHIP   = 8'(WBUF_LOG2 + 1 - CHIPS);
   localparam logic [7:0]  CHIP_SHIFT  = 8'(CHIPS - 1);

   logic [5:0]  blk_shift;
   logic [15:0] nblk_m1;
   logic [7:0]  chip_log2;

   assign blk_shift = cfg_size_log2 - 6'(BLOCK_LOG2);
   assign nblk_m1   = (16'd1 << blk_shift) - 16'd1;
   assign chip_log2 = {2'b00, cfg_size_log2} - CHIP_SHIFT;

   always_comb begin
      q_byte = 8'h00;
      if (idx < IDX_W'(QRY_TBL_LEN)) begin
         case (idx[6:0])
            7'h10: q_byte = 8'h51;
            7'h11: q_byte = 8'h52;
            7'h12: q_byte = 8'h59;
            7'h13: q_byte = 8'h01;
            7'h15: q_byte = 8'h31;
            7'h1B: q_byte = 8'h45;
            7'h1C: q_byte = 8'h55;
            7'h1F: q_byte = 8'h01;
            7'h20: q_byte = 8'h01;
            7'h21: q_byte = 8'h01;
            7'h27: q_byte = chip_log2;
            7'h28: q_byte = 8'h05;
            7'h2A: q_byte = WBUF_CHIP;
            7'h2C: q_byte = 8'h01;
            7'h2D: q_byte = nblk_m1[7:0];
            7'h2E: q_byte = nblk_m1[15:8];
            7'h2F: q_byte = BLK_UNITS[7:0];
            7'h30: q_byte = BLK_UNITS[15:8];
            7'h31: q_byte = 8'h50;
            7'h32: q_byte = 8'h52;
            7'h33: q_byte = 8'h49;
            7'h34: q_byte = 8'h31;
            7'h35: q_byte = 8'h30;
            7'h36: q_byte = 8'hA0;
            7'h3B: q_byte = 8'h01;
            7'h3D: q_byte = 8'h50;
            7'h3F: q_byte = 8'h01;
            default: q_byte = 8'h00;
         endcase
      end
   end
endmodule

// File: rtl/fqr_devid.sv
module fqr_devid #(
   parameter int ADDR_W     = 24,
   parameter int BLOCK_LOG2 = 16,
   parameter int NBLK       = 256
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [NBLK-1:0]   lock_bits,
   output logic [15:0]       id_val
);
   logic [8:0]                 entry;
   logic [ADDR_W-BLOCK_LOG2-1:0] blk;
   logic                       unused_bits;

   assign entry       = addr[10:2];
   assign blk         = addr[ADDR_W-1:BLOCK_LOG2];
   assign unused_bits = ^{addr[1:0], addr[BLOCK_LOG2-1:11]};

   always_comb begin
      case (entry)
         9'd0:    id_val = 16'h0000;
         9'd1:    id_val = 16'hFFFF;
         9'd2:    id_val = {15'd0, lock_bits[blk]};
         default: id_val = 16'h0000;
      endcase
   end
endmodule

// File: rtl/fqr_lane_pack.sv
module fqr_lane_pack
   import fqr_pkg::*;
#(
   parameter int CHIPS = 2
) (
   input  rd_mode_e    mode,
   input  rd_size_e    size,
   input  logic [31:0] mem_rdata,
   input  logic [15:0] val16,
   output logic [31:0] packed_data
);
   logic [15:0] upper_lane;

   generate
      if (CHIPS == 2) begin : g_dual
         assign upper_lane = val16;
      end else begin : g_single
         assign upper_lane = 16'h0000;
      end
   endgenerate

   always_comb begin
      if (mode == MODE_ARRAY) begin
         packed_data = mem_rdata;
      end else begin
         case (size)
            SZ_BYTE: packed_data = {24'h0, val16[7:0]};
            SZ_HALF: packed_data = {16'h0, val16};
            default: packed_data = {upper_lane, val16};
         endcase
      end
   end
endmodule

// File: rtl/flash_query_resp.sv
module flash_query_resp
   import fqr_pkg::*;
#(
   parameter int ADDR_W     = 24,
   parameter int BLOCK_LOG2 = 16,
   parameter int CHIPS      = 2,
   parameter int WBUF_LOG2  = 7
) (
   input  logic                                 clk,
   input  logic                                 rst_n,
   input  logic [1:0]                           rd_mode,
   input  logic [1:0]                           rd_size,
   input  logic [ADDR_W-1:0]                    rd_addr,
   input  logic [31:0]                          mem_rdata,
   input  logic [7:0]                           status,
   input  logic [(1<<(ADDR_W-BLOCK_LOG2))-1:0]  lock_bits,
   input  logic [5:0]                           cfg_size_log2,
   output logic [31:0]                          rd_data
);
   localparam int NBLK  = 1 << (ADDR_W - BLOCK_LOG2);
   localparam int IDX_W = ADDR_W - 2;

   generate
      if (CHIPS != 1 && CHIPS != 2) begin : g_bad_chips
         $error("CHIPS must be 1 or 2");
      end
      if (BLOCK_LOG2 <= 11 || BLOCK_LOG2 >= ADDR_W) begin : g_bad_block
         $error("BLOCK_LOG2 must exceed the ID mask and stay below ADDR_W");
      end
      if (ADDR_W > 32 || IDX_W < 7) begin : g_bad_addr
         $error("ADDR_W out of range");
      end
   endgenerate

   rd_mode_e    mode;
   rd_size_e    size;
   logic [7:0]  q_byte;
   logic [15:0] id_val;
   logic [15:0] val16;
   logic [31:0] packed_data;

   assign mode = rd_mode_e'(rd_mode);
   assign size = rd_size_e'(rd_size);

   fqr_query_rom #(
      .IDX_W(IDX_W), .CHIPS(CHIPS), .BLOCK_LOG2(BLOCK_LOG2), .WBUF_LOG2(WBUF_LOG2)
   ) u_rom (
      .idx(rd_addr[ADDR_W-1:2]),
      .cfg_size_log2(cfg_size_log2),
      .q_byte(q_byte)
   );

   fqr_devid #(
      .ADDR_W(ADDR_W), .BLOCK_LOG2(BLOCK_LOG2), .NBLK(NBLK)
   ) u_devid (
      .addr(rd_addr),
      .lock_bits(lock_bits),
      .id_val(id_val)
   );

   always_comb begin
      case (mode)
         MODE_STATUS: val16 = {8'h00, status};
         MODE_DEVID:  val16 = id_val;
         MODE_QUERY:  val16 = {8'h00, q_byte};
         default:     val16 = 16'h0000;
      endcase
   end

   fqr_lane_pack #(.CHIPS(CHIPS)) u_pack (
      .mode(mode),
      .size(size),
      .mem_rdata(mem_rdata),
      .val16(val16),
      .packed_data(packed_data)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rd_data <= 32'h0;
      else        rd_data <= packed_data;
   end

   // marks that rd_data has been loaded at least once since reset
   logic vld_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) vld_q <= 1'b0;
      else        vld_q <= 1'b1;
   end

   a_r1_reset_zero: assert property (@(posedge clk) !vld_q |-> rd_data == 32'h0);

   a_r2_array_pass: assert property (@(posedge clk) disable iff (!rst_n)
      vld_q && $past(rd_mode) == 2'd0 |-> rd_data == $past(mem_rdata));

   a_r3_status_val: assert property (@(posedge clk) disable iff (!rst_n)
      vld_q && $past(rd_mode) == 2'd1 && $past(rd_size) == 2'd1
      |-> rd_data == {24'h0, $past(status)});

   a_r9_query_tail: assert property (@(posedge clk) disable iff (!rst_n)
      vld_q && $past(rd_mode) == 2'd3 && $past(rd_addr[ADDR_W-1:2]) >= IDX_W'(QRY_TBL_LEN)
      |-> rd_data == 32'h0);

   a_r10_devid_one: assert property (@(posedge clk) disable iff (!rst_n)
      vld_q && $past(rd_mode) == 2'd2 && $past(rd_addr[10:2]) == 9'd1 && $past(rd_size) != 2'd0
      |-> rd_data[15:0] == 16'hFFFF);

   a_r11_lane_copy: assert property (@(posedge clk) disable iff (!rst_n)
      vld_q && $past(rd_mode) != 2'd0 && $past(rd_size[1]) && CHIPS == 2
      |-> rd_data[31:16] == rd_data[15:0]);

   a_r12_half_upper: assert property (@(posedge clk) disable iff (!rst_n)
      vld_q && $past(rd_mode) != 2'd0 && $past(rd_size) == 2'd1 |-> rd_data[31:16] == 16'h0);

   a_r13_byte_upper: assert property (@(posedge clk) disable iff (!rst_n)
      vld_q && $past(rd_mode) != 2'd0 && $past(rd_size) == 2'd0 |-> rd_data[31:8] == 24'h0);
endmodule

// File: tb/flash_query_resp_test.sv
`timescale 1ns/1ps
module flash_query_resp_test;
   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [1:0]    rd_mode = 2'd0;
   logic [1:0]    rd_size = 2'd2;
   logic [23:0]   rd_addr = 24'h0;
   logic [31:0]   mem_rdata = 32'h0;
   logic [7:0]    status = 8'h80;
   logic [255:0]  lock_bits = '0;
   logic [5:0]    cfg_size_log2 = 6'd20;
   logic [31:0]   rd_data;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   flash_query_resp uut (
      .clk(clk), .rst_n(rst_n), .rd_mode(rd_mode), .rd_size(rd_size),
      .rd_addr(rd_addr), .mem_rdata(mem_rdata), .status(status),
      .lock_bits(lock_bits), .cfg_size_log2(cfg_size_log2), .rd_data(rd_data)
   );

   task automatic check(input string req, input logic [31:0] exp);
      checks++;
      if (rd_data !== exp) begin
         errors++;
         $display("FAIL %s: got %08h expected %08h", req, rd_data, exp);
      end
   endtask

   // drive on falling edge, result registered on next rising edge, sample 1 ns later
   task automatic rd(input logic [1:0] m, input logic [1:0] s, input logic [23:0] a,
                     input string req, input logic [31:0] exp);
      @(negedge clk);
      rd_mode = m; rd_size = s; rd_addr = a;
      @(posedge clk);
      #1;
      check(req, exp);
   endtask

   task automatic t_reset;
      #1; check("R1 during reset", 32'h0);
      @(negedge clk); rd_mode = 2'd1; status = 8'h80;
      rst_n = 1'b1;
      #1; check("R1 after release", 32'h0);
   endtask

   task automatic t_array;
      @(negedge clk); mem_rdata = 32'hDEADBEEF;
      rd(2'd0, 2'd2, 24'h000100, "R2 word", 32'hDEADBEEF);
      @(negedge clk); mem_rdata = 32'h12345678;
      rd(2'd0, 2'd0, 24'h000101, "R2 byte size", 32'h12345678);
   endtask

   task automatic t_status;
      @(negedge clk); status = 8'hB2;
      rd(2'd1, 2'd1, 24'h0, "R3 half", 32'h000000B2);
      rd(2'd1, 2'd2, 24'h123456, "R3 word", 32'h00B200B2);
   endtask

   task automatic t_query_id;
      rd(2'd3, 2'd2, 24'h10 << 2, "R4 Q", 32'h00510051);
      rd(2'd3, 2'd1, 24'h11 << 2, "R4 R", 32'h00000052);
      rd(2'd3, 2'd0, 24'h12 << 2, "R4 Y", 32'h00000059);
      rd(2'd3, 2'd0, 24'h13 << 2, "R4 cmd set", 32'h00000001);
      rd(2'd3, 2'd0, 24'h15 << 2, "R4 ext ptr", 32'h00000031);
      rd(2'd3, 2'd0, (24'h16 << 2) | 24'h3, "R4 byte lanes ignored", 32'h00000000);
   endtask

   task automatic t_geometry(input logic [5:0] lg, input logic [7:0] e27,
                             input logic [7:0] e2d, input logic [7:0] e2e);
      @(negedge clk); cfg_size_log2 = lg;
      rd(2'd3, 2'd0, 24'h27 << 2, "R5 chip size", {24'h0, e27});
      rd(2'd3, 2'd0, 24'h2D << 2, "R6 blocks lo", {24'h0, e2d});
      rd(2'd3, 2'd0, 24'h2E << 2, "R6 blocks hi", {24'h0, e2e});
      rd(2'd3, 2'd2, 24'h2F << 2, "R7 block lo", 32'h00800080);
      rd(2'd3, 2'd2, 24'h30 << 2, "R7 block hi", 32'h00000000);
   endtask

   task automatic t_ext;
      rd(2'd3, 2'd0, 24'h31 << 2, "R8 P", 32'h50);
      rd(2'd3, 2'd0, 24'h32 << 2, "R8 R", 32'h52);
      rd(2'd3, 2'd0, 24'h33 << 2, "R8 I", 32'h49);
      rd(2'd3, 2'd0, 24'h34 << 2, "R8 1", 32'h31);
      rd(2'd3, 2'd0, 24'h35 << 2, "R8 0", 32'h30);
      rd(2'd3, 2'd0, 24'h2A << 2, "R8 wbuf", 32'h06);
   endtask

   task automatic t_tail;
      rd(2'd3, 2'd2, 24'h43 << 2, "R9 last entry", 32'h0);
      rd(2'd3, 2'd2, 24'h44 << 2, "R9 first past end", 32'h0);
      rd(2'd3, 2'd2, 24'h80 << 2 | 24'h10 << 2, "R9 alias of Q", 32'h0);
   endtask

   task automatic t_devid;
      @(negedge clk); lock_bits = '0; lock_bits[5] = 1'b1;
      rd(2'd2, 2'd2, 24'h000000, "R10 vendor", 32'h0);
      rd(2'd2, 2'd2, 24'h000004, "R10 device", 32'hFFFFFFFF);
      rd(2'd2, 2'd1, 24'h050008, "R10 lock set", 32'h00000001);
      rd(2'd2, 2'd1, 24'h050808, "R10 mask 0x7FF", 32'h00000001);
      rd(2'd2, 2'd1, 24'h060008, "R10 lock clear", 32'h0);
      rd(2'd2, 2'd2, 24'h00000C, "R10 other entry", 32'h0);
      rd(2'd2, 2'd0, 24'h000004, "R13 byte", 32'h000000FF);
      rd(2'd2, 2'd1, 24'h000004, "R12 half", 32'h0000FFFF);
      rd(2'd2, 2'd3, 24'h000004, "R11 size 3", 32'hFFFFFFFF);
   endtask

   // modes, addresses and sizes change together on consecutive edges
   task automatic t_back_to_back;
      @(negedge clk); mem_rdata = 32'hA5A55A5A; status = 8'h9C;
      rd(2'd0, 2'd1, 24'h000040, "R2 b2b array", 32'hA5A55A5A);
      rd(2'd3, 2'd2, 24'h10 << 2, "R11 b2b query", 32'h00510051);
      rd(2'd2, 2'd0, 24'h000004, "R13 b2b devid", 32'h000000FF);
      rd(2'd1, 2'd2, 24'h000004, "R11 b2b status", 32'h009C009C);
      rd(2'd0, 2'd2, 24'h000004, "R2 b2b array again", 32'hA5A55A5A);
   endtask

   initial begin
      t_reset;
      t_array;
      t_status;
      t_query_id;
      t_geometry(6'd20, 8'h13, 8'h0F, 8'h00);
      t_geometry(6'd24, 8'h17, 8'hFF, 8'h00);
      t_ext;
      t_tail;
      t_devid;
      t_back_to_back;
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (20000) @(posedge clk);
            checks++; errors++;
            $display("FAIL watchdog: got timeout expected completion");
         end
      join_any
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule